// File: doc/BRIEF.md
# Reloadable Timer Transfer Unit

This block holds three down-counting timers with reload registers inside a small 4-bit processor. It decodes 10-bit transfer opcodes that copy a timer's count into the processor's A, B and W5 registers, or write A, B and W5 into a timer and its reload storage. Timer 1 is 10 bits wide, and its top two bits travel through W5. Timers 2 and 3 are 8 bits wide. In every byte transfer B carries the high nibble and A carries the low nibble.

Each timer has its own run bit and its own count-enable pulse. A running timer steps down once per pulse. When it steps past zero it reloads from its reload storage and raises a one-cycle underflow pulse. Timer 3 has two reload registers, one for the low phase and one for the high phase, and it switches between them on every underflow. The result is a waveform whose two phase lengths can be set separately.

A read opcode does not change the processor registers directly. In the same cycle the block drives the value and a write strobe, and the processor's register file takes the value on the next clock edge.

Top module: `tmr_xfer_unit`

## Requirements
- R1: After reset, every counter and every reload register is zero, the underflow outputs are low, and the timer-3 phase pointer selects the low phase.
- R2: When op_valid is high and op_code is 0x270, ab_we and w5_we are both high in the same cycle. w5_out carries count bits 9:8 of timer 1, b_out carries bits 7:4 and a_out carries bits 3:0.
- R3: Opcode 0x230 writes the value {w5_in, b_in, a_in} to timer 1. If run_en[0] is 0, the value goes to both the counter and the reload register. If run_en[0] is 1, it goes to the reload register only.
- R4: Opcode 0x271 reads timer 2 to {b_out, a_out} with w5_we low. Opcode 0x231 loads {b_in, a_in} into both the timer-2 counter and its reload register. Opcode 0x23A loads the timer-2 reload register only.
- R5: Opcode 0x272 reads timer 3 to {b_out, a_out} with w5_we low. Opcode 0x232 loads {b_in, a_in} into the timer-3 counter and its low-phase reload register, and it resets the phase pointer to low. Opcode 0x23D loads the high-phase reload register only.
- R6: In a cycle where op_valid is low, or op_code is not one of the eight listed opcodes, no timer state changes except by counting, and ab_we and w5_we stay low.
- R7: Timer i, with bit i of run_en set, decrements by one on each cycle where bit i of cnt_en is high. With its run bit clear, it holds its count.
- R8: A running, enabled timer whose count is zero, and which is not being loaded, reloads from its reload register. Bit i of uf is then high for exactly the next cycle. In the same cycle a reload register write does not affect that reload: the old value is used.
- R9: Timer 3 reloads from the high-phase register when it underflows in the low phase, and from the low-phase register when it underflows in the high phase. The phase pointer flips on every underflow.
- R10: When a counter load and a count-enable pulse arrive in the same cycle, the counter takes the loaded value and no decrement or underflow takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | op_code is valid this cycle |
| op_code | input | 10 | Transfer opcode |
| a_in | input | 4 | Current value of register A |
| b_in | input | 4 | Current value of register B |
| w5_in | input | 2 | Current value of register W5 |
| run_en | input | 3 | Run bit per timer (bit 0 = timer 1) |
| cnt_en | input | 3 | Count-enable pulse per timer |
| a_out | output | 4 | Value to be written to A |
| b_out | output | 4 | Value to be written to B |
| w5_out | output | 2 | Value to be written to W5 |
| ab_we | output | 1 | Write strobe for A and B |
| w5_we | output | 1 | Write strobe for W5 |
| uf | output | 3 | One-cycle underflow pulse per timer |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles and a 2-bit W5 field, which gives a 10-bit timer 1 and 8-bit timers 2 and 3. Random write data is often masked to small values, so that counters reach zero within a few pulses. This brings underflow, reload and the timer-3 phase alternation within reach many times over. It also brings loads that coincide with count pulses or with wraps, and reload writes that land in the same cycle as an underflow.

// File: rtl/tmr_xfer_pkg.sv
`timescale 1ns/1ps
package tmr_xfer_pkg;
  localparam int OPW = 10;

  localparam logic [OPW-1:0] OP_RD_T1  = 10'h270;
  localparam logic [OPW-1:0] OP_WR_T1  = 10'h230;
  localparam logic [OPW-1:0] OP_RD_T2  = 10'h271;
  localparam logic [OPW-1:0] OP_WR_T2  = 10'h231;
  localparam logic [OPW-1:0] OP_WR_R2  = 10'h23A;
  localparam logic [OPW-1:0] OP_RD_T3  = 10'h272;
  localparam logic [OPW-1:0] OP_WR_T3  = 10'h232;
  localparam logic [OPW-1:0] OP_WR_R3H = 10'h23D;

  typedef struct packed {
    logic rd1;
    logic wr1;
    logic rd2;
    logic wr2;
    logic wr2r;
    logic rd3;
    logic wr3;
    logic wr3h;
  } xfer_dec_t;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} t3_phase_e;

  // Opcode decode: exactly one field set for a known opcode when valid.
  function automatic xfer_dec_t decode_op(input logic valid, input logic [OPW-1:0] op);
    xfer_dec_t d;
    d = '0;
    if (valid) begin
      unique case (op)
        OP_RD_T1:  d.rd1  = 1'b1;
        OP_WR_T1:  d.wr1  = 1'b1;
        OP_RD_T2:  d.rd2  = 1'b1;
        OP_WR_T2:  d.wr2  = 1'b1;
        OP_WR_R2:  d.wr2r = 1'b1;
        OP_RD_T3:  d.rd3  = 1'b1;
        OP_WR_T3:  d.wr3  = 1'b1;
        OP_WR_R3H: d.wr3h = 1'b1;
        default:   d = '0;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/tmr_xfer_decode.sv
`timescale 1ns/1ps
module tmr_xfer_decode
  import tmr_xfer_pkg::*;
(
  input  logic                 op_valid,
  input  logic [OPW-1:0]       op_code,
  output xfer_dec_t            dec
);
  always_comb dec = decode_op(op_valid, op_code);
endmodule

// File: rtl/tmr_down_cnt.sv
`timescale 1ns/1ps
module tmr_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] rel_val,
  output logic [W-1:0] count,
  output logic         uf,
  output logic         wrap
);
  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return v - {{(W-1){1'b0}}, 1'b1};
  endfunction

  logic step;
  assign step = run && tick && !ld;
  assign wrap = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      uf    <= 1'b0;
    end else begin
      uf <= wrap;
      if (ld)        count <= ld_val;
      else if (wrap) count <= rel_val;
      else if (step) count <= step_down(count);
    end
  end
endmodule

// File: rtl/tmr3_phase.sv
`timescale 1ns/1ps
module tmr3_phase
  import tmr_xfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         wrap,
  input  logic [W-1:0] rel_lo,
  input  logic [W-1:0] rel_hi,
  output logic [W-1:0] rel_val,
  output t3_phase_e    phase
);
  // Reload picks the phase that follows the current one.
  assign rel_val = (phase == PH_LOW) ? rel_hi : rel_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= PH_LOW;
    else if (restart)  phase <= PH_LOW;
    else if (wrap)     phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
  end
endmodule

// File: rtl/tmr_xfer_unit.sv
`timescale 1ns/1ps
module tmr_xfer_unit
  import tmr_xfer_pkg::*;
#(
  parameter int NIB = 4,
  parameter int W5W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [NIB-1:0] a_in,
  input  logic [NIB-1:0] b_in,
  input  logic [W5W-1:0] w5_in,
  input  logic [2:0]     run_en,
  input  logic [2:0]     cnt_en,
  output logic [NIB-1:0] a_out,
  output logic [NIB-1:0] b_out,
  output logic [W5W-1:0] w5_out,
  output logic           ab_we,
  output logic           w5_we,
  output logic [2:0]     uf
);
  localparam int BW  = 2 * NIB;
  localparam int T1W = BW + W5W;

  xfer_dec_t        dec;
  logic [BW-1:0]    ab_val;
  logic [T1W-1:0]   ld1_val;
  logic [T1W-1:0]   cnt1, r1;
  logic [BW-1:0]    cnt2, r2, cnt3, r3l, r3h, rel3;
  logic             ld1_cnt, ld1_rel, ld2_cnt, ld2_rel, ld3_cnt;
  logic             wrap1, wrap2, wrap3;
  t3_phase_e        phase3;

  tmr_xfer_decode u_dec (.op_valid(op_valid), .op_code(op_code), .dec(dec));

  assign ab_val  = {b_in, a_in};
  assign ld1_val = {w5_in, b_in, a_in};
  assign ld1_rel = dec.wr1;
  assign ld1_cnt = dec.wr1 && !run_en[0];
  assign ld2_cnt = dec.wr2;
  assign ld2_rel = dec.wr2 || dec.wr2r;
  assign ld3_cnt = dec.wr3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1  <= '0;
      r2  <= '0;
      r3l <= '0;
      r3h <= '0;
    end else begin
      if (ld1_rel)  r1  <= ld1_val;
      if (ld2_rel)  r2  <= ab_val;
      if (dec.wr3)  r3l <= ab_val;
      if (dec.wr3h) r3h <= ab_val;
    end
  end

  tmr_down_cnt #(.W(T1W)) u_t1 (
    .clk(clk), .rst_n(rst_n), .run(run_en[0]), .tick(cnt_en[0]),
    .ld(ld1_cnt), .ld_val(ld1_val), .rel_val(r1),
    .count(cnt1), .uf(uf[0]), .wrap(wrap1));

  tmr_down_cnt #(.W(BW)) u_t2 (
    .clk(clk), .rst_n(rst_n), .run(run_en[1]), .tick(cnt_en[1]),
    .ld(ld2_cnt), .ld_val(ab_val), .rel_val(r2),
    .count(cnt2), .uf(uf[1]), .wrap(wrap2));

  tmr_down_cnt #(.W(BW)) u_t3 (
    .clk(clk), .rst_n(rst_n), .run(run_en[2]), .tick(cnt_en[2]),
    .ld(ld3_cnt), .ld_val(ab_val), .rel_val(rel3),
    .count(cnt3), .uf(uf[2]), .wrap(wrap3));

  tmr3_phase #(.W(BW)) u_ph3 (
    .clk(clk), .rst_n(rst_n), .restart(ld3_cnt), .wrap(wrap3),
    .rel_lo(r3l), .rel_hi(r3h), .rel_val(rel3), .phase(phase3));

  // Read path towards the register file.
  always_comb begin
    a_out  = '0;
    b_out  = '0;
    w5_out = '0;
    ab_we  = 1'b0;
    w5_we  = 1'b0;
    if (dec.rd1) begin
      {w5_out, b_out, a_out} = cnt1;
      ab_we = 1'b1;
      w5_we = 1'b1;
    end else if (dec.rd2) begin
      {b_out, a_out} = cnt2;
      ab_we = 1'b1;
    end else if (dec.rd3) begin
      {b_out, a_out} = cnt3;
      ab_we = 1'b1;
    end
  end
endmodule

// File: rtl/tmr_xfer_unit_chk.sv
`timescale 1ns/1ps
module tmr_xfer_unit_chk
  import tmr_xfer_pkg::*;
#(
  parameter int BW  = 8,
  parameter int T1W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic           ab_we,
  input logic           w5_we,
  input logic [2:0]     run_en,
  input logic [2:0]     cnt_en,
  input logic [2:0]     uf,
  input logic [T1W-1:0] cnt1,
  input logic [T1W-1:0] r1,
  input logic [T1W-1:0] ld1_val,
  input logic           ld1_cnt,
  input logic           wrap1,
  input logic [BW-1:0]  cnt2,
  input logic [BW-1:0]  ab_val,
  input logic           ld2_cnt,
  input logic           wrap3,
  input t3_phase_e      phase3
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!ab_we && !w5_we)); // R6
  AST_W5_WITH_AB: assert property (@(posedge clk) disable iff (!rst_n)
    w5_we |-> ab_we); // R2
  AST_T1_LOAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ld1_cnt |-> !run_en[0]); // R3
  AST_T1_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld1_cnt |=> cnt1 == $past(ld1_val)); // R3
  AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en[0] && !ld1_cnt) |=> $stable(cnt1)); // R7
  AST_T1_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap1 |=> (uf[0] && cnt1 == $past(r1))); // R8
  AST_T2_UF_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    uf[1] |-> $past(cnt2) == '0); // R8
  AST_T3_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    wrap3 |=> phase3 != $past(phase3)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld2_cnt && run_en[1] && cnt_en[1]) |=> (cnt2 == $past(ab_val) && !uf[1])); // R10
endmodule

bind tmr_xfer_unit tmr_xfer_unit_chk #(.BW(BW), .T1W(T1W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .ab_we(ab_we), .w5_we(w5_we),
  .run_en(run_en), .cnt_en(cnt_en), .uf(uf), .cnt1(cnt1), .r1(r1),
  .ld1_val(ld1_val), .ld1_cnt(ld1_cnt), .wrap1(wrap1), .cnt2(cnt2),
  .ab_val(ab_val), .ld2_cnt(ld2_cnt), .wrap3(wrap3), .phase3(phase3));

// File: tb/tmr_xfer_unit_bench.sv
`timescale 1ns/1ps
module tmr_xfer_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [9:0] op_code = '0;
  logic [3:0] a_in = '0, b_in = '0;
  logic [1:0] w5_in = '0;
  logic [2:0] run_en = '0, cnt_en = '0;
  logic [3:0] a_out, b_out;
  logic [1:0] w5_out;
  logic       ab_we, w5_we;
  logic [2:0] uf;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference state
  int m1, mr1, m2, mr2, m3, m3lo, m3hi;
  bit mhigh;
  logic [2:0] muf;

  always #2.5 clk = ~clk;

  tmr_xfer_unit u_tmr_xfer_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .a_in(a_in), .b_in(b_in), .w5_in(w5_in), .run_en(run_en), .cnt_en(cnt_en),
    .a_out(a_out), .b_out(b_out), .w5_out(w5_out), .ab_we(ab_we), .w5_we(w5_we),
    .uf(uf));

  function automatic string tag_for(logic v, logic [9:0] op);
    if (!v) return "R6";
    case (op)
      10'h270: return "R2";
      10'h230: return "R3";
      10'h271, 10'h231, 10'h23A: return "R4";
      10'h272, 10'h232, 10'h23D: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Next value of one timer: load beats counting, zero wraps to reload.
  function automatic int next_cnt(int cur, bit ld, int ldv, bit go, int rel);
    if (ld) return ldv;
    if (!go) return cur;
    if (cur == 0) return rel;
    return cur - 1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [9:0] op, logic [3:0] a, logic [3:0] b,
                      logic [1:0] w, logic [2:0] run, logic [2:0] tick, string tag);
    bit is_op, l1, l2, l3, go1, go2, go3;
    int abv, w1v;
    @(negedge clk);
    check("R8", uf[0], muf[0], "uf timer1");
    check("R8", uf[1], muf[1], "uf timer2");
    check("R9", uf[2], muf[2], "uf timer3");
    op_valid = v; op_code = op; a_in = a; b_in = b; w5_in = w;
    run_en = run; cnt_en = tick;
    #1;
    if (v && op == 10'h270) begin
      check(tag, ab_we, 1, "ab_we t1 read");
      check(tag, w5_we, 1, "w5_we t1 read");
      check(tag, {w5_out, b_out, a_out}, m1, "t1 read data");
    end else if (v && op == 10'h271) begin
      check(tag, {w5_we, ab_we}, 1, "strobes t2 read");
      check(tag, {b_out, a_out}, m2, "t2 read data");
    end else if (v && op == 10'h272) begin
      check(tag, {w5_we, ab_we}, 1, "strobes t3 read");
      check(tag, {b_out, a_out}, m3, "t3 read data");
    end else begin
      check(tag, {w5_we, ab_we}, 0, "strobes idle");
    end
    abv = b * 16 + a;
    w1v = w * 256 + abv;
    is_op = v;
    l1 = is_op && op == 10'h230 && !run[0];
    l2 = is_op && op == 10'h231;
    l3 = is_op && op == 10'h232;
    go1 = run[0] && tick[0] && !l1;
    go2 = run[1] && tick[1] && !l2;
    go3 = run[2] && tick[2] && !l3;
    muf[0] = go1 && m1 == 0;
    muf[1] = go2 && m2 == 0;
    muf[2] = go3 && m3 == 0;
    m1 = next_cnt(m1, l1, w1v, go1, mr1);
    m2 = next_cnt(m2, l2, abv, go2, mr2);
    m3 = next_cnt(m3, l3, abv, go3, mhigh ? m3lo : m3hi);
    if (l3) mhigh = 0;
    else if (muf[2]) mhigh = !mhigh;
    if (is_op && op == 10'h230) mr1 = w1v;
    if (is_op && (op == 10'h231 || op == 10'h23A)) mr2 = abv;
    if (is_op && op == 10'h232) m3lo = abv;
    if (is_op && op == 10'h23D) m3hi = abv;
  endtask

  task automatic rd(logic [9:0] op, logic [2:0] run, string tag);
    step(1, op, 0, 0, 0, run, 3'b000, tag);
  endtask

  initial begin
    logic [9:0] ops [8] = '{10'h270, 10'h230, 10'h271, 10'h231,
                            10'h23A, 10'h272, 10'h232, 10'h23D};
    logic [2:0] run;
    void'($urandom(32'd20240611));
    m1 = 0; mr1 = 0; m2 = 0; mr2 = 0; m3 = 0; m3lo = 0; m3hi = 0;
    mhigh = 0; muf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(10'h270, 0, "R1"); rd(10'h271, 0, "R1"); rd(10'h272, 0, "R1");
    // R1: R3H and R3L zero -> timer3 running from 0 wraps to 0
    step(0, 0, 0, 0, 0, 3'b100, 3'b100, "R1");
    rd(10'h272, 0, "R1");

    // R3: stopped write loads counter; running write leaves count alone
    step(1, 10'h230, 4'h5, 4'hA, 2'h2, 0, 0, "R3");
    rd(10'h270, 0, "R3");
    step(1, 10'h230, 4'hC, 4'h3, 2'h1, 3'b001, 0, "R3");
    rd(10'h270, 3'b001, "R2");

    // R7: hold when stopped, decrement when running
    step(1, 10'h231, 4'h0, 4'h4, 0, 0, 0, "R4");
    repeat (3) step(0, 0, 0, 0, 0, 3'b000, 3'b010, "R7");
    rd(10'h271, 0, "R7");
    repeat (3) step(0, 0, 0, 0, 0, 3'b010, 3'b010, "R7");
    rd(10'h271, 0, "R7");

    // R10: load with a simultaneous count pulse
    step(1, 10'h231, 4'h9, 4'h1, 0, 3'b010, 3'b010, "R10");
    rd(10'h271, 0, "R10");

    // R8: timer1 wraps to its reload
    step(1, 10'h230, 4'h2, 4'h0, 0, 0, 0, "R3");
    repeat (4) step(0, 0, 0, 0, 0, 3'b001, 3'b001, "R8");
    rd(10'h270, 0, "R8");

    // R4: reload-only write leaves count
    step(1, 10'h23A, 4'h1, 4'h0, 0, 0, 0, "R4");
    rd(10'h271, 0, "R4");
    step(1, 10'h231, 4'h0, 4'h0, 0, 0, 0, "R4");
    repeat (3) step(0, 0, 0, 0, 0, 3'b010, 3'b010, "R8");
    rd(10'h271, 0, "R8");

    // R9: alternating timer3 phases
    step(1, 10'h23D, 4'h3, 4'h0, 0, 0, 0, "R5");
    step(1, 10'h232, 4'h1, 4'h0, 0, 0, 0, "R5");
    for (int i = 0; i < 14; i++) begin
      step(0, 0, 0, 0, 0, 3'b100, 3'b100, "R9");
      if (i % 3 == 2) rd(10'h272, 0, "R9");
    end

    // R6: unknown opcodes and invalid strobes
    step(1, 10'h273, 4'hF, 4'hF, 3, 0, 0, "R6");
    step(1, 10'h233, 4'hF, 4'hF, 3, 0, 0, "R6");
    step(0, 10'h230, 4'hF, 4'hF, 3, 0, 0, "R6");
    step(0, 10'h270, 4'hF, 4'hF, 3, 0, 0, "R6");
    rd(10'h270, 0, "R6"); rd(10'h271, 0, "R6"); rd(10'h272, 0, "R6");

    // Random traffic
    run = 3'b111;
    for (int i = 0; i < 4000; i++) begin
      logic       v;
      logic [9:0] op;
      logic [3:0] a, b;
      logic [1:0] w;
      v  = ($urandom % 8) != 0;
      op = (($urandom % 6) == 0) ? 10'($urandom) : ops[$urandom % 8];
      a  = 4'($urandom);
      b  = (($urandom % 4) != 0) ? 4'h0 : 4'($urandom);
      w  = (($urandom % 4) != 0) ? 2'h0 : 2'($urandom);
      for (int k = 0; k < 3; k++) if (($urandom % 16) == 0) run[k] = ~run[k];
      step(v, op, a, b, w, run, 3'($urandom), tag_for(v, op));
    end
    step(0, 0, 0, 0, 0, 0, 0, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule